// File: doc/BRIEF.md
# Periodic Calibration Sequencer

This block steps through a short, fixed list of receiver calibrations: IQ mismatch first, then temperature compensation. Each calibration type is waiting, running or done. For the running type, the sequencer raises a measurement request bit. The measurement unit clears that bit when its measurement window is over. The sequencer then strobes the downstream accumulators to collect one sample and launches the next measurement straight away. It repeats this until the required number of samples is collected.

After the last sample, the sequencer issues a post-processing strobe. The strobe carries the number of active receive chains, which is the count of set bits in the chain mask. In the same cycle it marks the type valid. If the following type in the circular list is still waiting, the sequencer starts it at once and keeps its completion output low, so the caller sees a single completion for the whole list. A start request clears the valid mask and restarts the list at the first supported type. A start request that arrives while a calibration is in flight is dropped.

Top module: `cal_seq`

## Requirements
- R1: While reset is high and in the first idle cycle after it, go_o, collect_o, post_o, done_o and acc_clr_o are low and valid_o is 0.
- R2: A start (init_i high while idle) produces, in the next cycle, valid_o = 0, an acc_clr_o pulse, go_o high and cal_sel_o set to the first supported type (0 = IQ mismatch, 1 = temperature compensation).
- R3: go_o stays high until meas_fin_i is sampled high, and goes low in the following cycle. No collect_o pulse occurs while go_o is high.
- R4: In the cycle after go_o is seen low, collect_o pulses. If fewer than SAMPLES samples have been collected for the type, go_o is high again in that same cycle.
- R5: Exactly one cycle after the SAMPLES-th collect_o, post_o pulses. chains_o then holds the number of set bits in rx_chain_mask_i (0 to 3).
- R6: A valid_o bit is set only in a cycle where post_o is high, and the bit set is that of the finishing type (bit 0 IQ mismatch, bit 1 temperature compensation).
- R7: When a type finishes and the next type is waiting, done_o stays low. In the same cycle as post_o, acc_clr_o pulses, go_o rises and cal_sel_o moves to the next type.
- R8: done_o is a one-cycle pulse. It is given once per start, together with the post_o of the last type.
- R9: init_i while a calibration is in progress has no effect: no acc_clr_o, valid_o unchanged, and the total of collect_o pulses for the pass stays 2*SAMPLES.
- R10: The sample counter restarts for every type, so each type receives exactly SAMPLES collect_o pulses, seen with its own cal_sel_o value.
- R11: log_cnt_o equals LOG_COUNT (so the window is 2^(LOG_COUNT+1) samples) whenever go_o is high with cal_sel_o = 0, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Start request: clear valid mask, run the list from the first supported type |
| meas_fin_i | input | 1 | Measurement unit clears the request bit |
| rx_chain_mask_i | input | CHAINS | Receive chain enable mask |
| go_o | output | 1 | Measurement request bit (set by the sequencer, cleared by the unit) |
| cal_sel_o | output | 1 | Calibration type being run: 0 IQ mismatch, 1 temperature |
| log_cnt_o | output | LOG_W | Sample window log count for IQ measurements |
| collect_o | output | 1 | Accumulate-one-sample strobe |
| acc_clr_o | output | 1 | Clear per-chain accumulators strobe (type restart) |
| post_o | output | 1 | Post-processing strobe |
| chains_o | output | 2 | Active chain count given with post_o |
| done_o | output | 1 | One-cycle completion pulse for the whole list |
| valid_o | output | 2 | Per-type valid mask |

## Verification
The hardest cases to reach are a start request that lands in the middle of a measurement and the exact cycle in which a measurement is relaunched. The free-running measurement model hides both, because it answers every request on its own. For these tests the bench switches that model off and drives the finish pulse by hand. It holds the request open for several cycles, repeats the start request while a type is running, and then hands control back to the model to finish the pass. Varied chain masks and measurement latencies, read from a table, exercise the chain count and the hand-off from one type to the next.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  localparam int NUM_CAL  = 2;
  localparam int SEL_W    = 1;
  localparam int CAL_IQ   = 0;
  localparam int CAL_TEMP = 1;

  typedef enum logic [1:0] {CS_WAIT, CS_RUN, CS_DONE} cal_state_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_MEAS, SQ_POST} seq_state_e;

  function automatic int first_set(input logic [NUM_CAL-1:0] en);
    int r;
    r = 0;
    for (int i = NUM_CAL - 1; i >= 0; i--) begin
      if (en[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/cal_seq_popcnt.sv
module cal_seq_popcnt #(
  parameter int W = 3,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) begin
      count_o = count_o + CW'(bits_i[i]);
    end
  end
endmodule

// File: rtl/cal_seq_cnt.sv
module cal_seq_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i && !last_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_seq_gobit.sv
module cal_seq_gobit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic fin_i,
  output logic go_o
);
  always_ff @(posedge clk) begin
    if (rst) go_o <= 1'b0;
    else if (set_i) go_o <= 1'b1;
    else if (fin_i) go_o <= 1'b0;
  end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_seq_pkg::*;
#(
  parameter int SAMPLES = 4,
  parameter int CHAINS = 3,
  parameter int LOG_W = 4,
  parameter logic [LOG_W-1:0] LOG_COUNT = 4'd9,
  parameter logic [NUM_CAL-1:0] TYPE_EN = 2'b11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              meas_fin_i,
  input  logic [CHAINS-1:0] rx_chain_mask_i,
  output logic              go_o,
  output logic [SEL_W-1:0]  cal_sel_o,
  output logic [LOG_W-1:0]  log_cnt_o,
  output logic              collect_o,
  output logic              acc_clr_o,
  output logic              post_o,
  output logic [1:0]        chains_o,
  output logic              done_o,
  output logic [NUM_CAL-1:0] valid_o
);
  localparam int CCW = $clog2(CHAINS + 1);
  localparam int FIRST = first_set(TYPE_EN);
  localparam logic [SEL_W-1:0] FIRST_SEL = SEL_W'(FIRST);
  localparam bit ANY_EN = |TYPE_EN;

  seq_state_e st;
  logic [SEL_W-1:0] cur, nxt;
  cal_state_e tst [NUM_CAL];
  logic accept_init, meas_end, chain, launch_new, launch, last_sample;
  logic [CCW-1:0] pop;

  // Control decode
  assign accept_init = (st == SQ_IDLE) && init_i;
  assign meas_end    = (st == SQ_MEAS) && !go_o;
  assign nxt         = (cur == SEL_W'(NUM_CAL - 1)) ? '0 : cur + 1'b1;
  assign chain       = (st == SQ_POST) && (tst[nxt] == CS_WAIT);
  assign launch_new  = (accept_init && ANY_EN) || chain;
  assign launch      = launch_new || (meas_end && !last_sample);

  cal_seq_popcnt #(.W(CHAINS)) u_pop (
    .bits_i (rx_chain_mask_i),
    .count_o(pop)
  );

  cal_seq_cnt #(.LIMIT(SAMPLES)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (launch_new),
    .inc_i (meas_end),
    .last_o(last_sample)
  );

  cal_seq_gobit u_go (
    .clk  (clk),
    .rst  (rst),
    .set_i(launch),
    .fin_i(meas_fin_i),
    .go_o (go_o)
  );

  // Per-type state and valid flag
  for (genvar g = 0; g < NUM_CAL; g++) begin : g_type
    localparam logic [SEL_W-1:0] GS = SEL_W'(g);
    cal_state_e ts_q;
    logic       v_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        ts_q <= CS_DONE;
        v_q  <= 1'b0;
      end else if (accept_init) begin
        v_q <= 1'b0;
        if (ANY_EN && g == FIRST) ts_q <= CS_RUN;
        else if (TYPE_EN[g])      ts_q <= CS_WAIT;
        else                      ts_q <= CS_DONE;
      end else if (st == SQ_POST && cur == GS) begin
        ts_q <= CS_DONE;
        v_q  <= 1'b1;
      end else if (chain && nxt == GS) begin
        ts_q <= CS_RUN;
      end
    end
    assign tst[g]     = ts_q;
    assign valid_o[g] = v_q;
  end

  // Sequencer and strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      cur       <= '0;
      collect_o <= 1'b0;
      post_o    <= 1'b0;
      acc_clr_o <= 1'b0;
      done_o    <= 1'b0;
      chains_o  <= '0;
    end else begin
      collect_o <= meas_end;
      post_o    <= (st == SQ_POST);
      acc_clr_o <= launch_new;
      done_o    <= ((st == SQ_POST) && !chain) || (accept_init && !ANY_EN);
      if (st == SQ_POST) chains_o <= 2'(pop);
      if (launch_new) cur <= chain ? nxt : FIRST_SEL;
      unique case (st)
        SQ_IDLE: if (accept_init && ANY_EN) st <= SQ_MEAS;
        SQ_MEAS: if (meas_end && last_sample) st <= SQ_POST;
        SQ_POST: st <= chain ? SQ_MEAS : SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign cal_sel_o = cur;
  assign log_cnt_o = (go_o && cur == SEL_W'(CAL_IQ)) ? LOG_COUNT : '0;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk (
  input logic clk,
  input logic rst,
  input logic go_o,
  input logic collect_o,
  input logic post_o,
  input logic done_o,
  input logic acc_clr_o,
  input logic [cal_seq_pkg::NUM_CAL-1:0] valid_o
);
  a_r2_clear_with_launch: assert property (@(posedge clk) disable iff (rst)
    acc_clr_o |-> go_o);
  a_r3_collect_after_drop: assert property (@(posedge clk) disable iff (rst)
    collect_o |-> !$past(go_o));
  a_r4_no_relaunch_posts: assert property (@(posedge clk) disable iff (rst)
    (collect_o && !go_o) |=> post_o);
  a_r5_post_after_collect: assert property (@(posedge clk) disable iff (rst)
    post_o |-> $past(collect_o));
  a_r6_valid_rises_on_post: assert property (@(posedge clk) disable iff (rst)
    ((valid_o & ~$past(valid_o)) != '0) |-> post_o);
  a_r7_handoff_hides_done: assert property (@(posedge clk) disable iff (rst)
    (post_o && go_o) |-> !done_o);
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

bind cal_seq cal_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .go_o     (go_o),
  .collect_o(collect_o),
  .post_o   (post_o),
  .done_o   (done_o),
  .acc_clr_o(acc_clr_o),
  .valid_o  (valid_o)
);

// File: tb/sim_cal_seq.sv
`timescale 1ns/1ps
module sim_cal_seq;
  localparam int SAMPLES = 4;
  localparam logic [3:0] LOGC = 4'd9;
  // {mask[2:0], expected chain count[1:0], measurement latency[2:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b000_00_001, 8'b001_01_010, 8'b010_01_011, 8'b100_01_001,
    8'b011_10_100, 8'b101_10_010, 8'b110_10_101, 8'b111_11_111};

  logic clk = 1'b0, rst = 1'b1, init_i = 1'b0;
  logic fin_man = 1'b0, fin_auto = 1'b0, auto_meas = 1'b0, meas_fin;
  logic [2:0] mask = '0;
  logic go_o, collect_o, acc_clr_o, post_o, done_o;
  logic [0:0] cal_sel_o;
  logic [3:0] log_cnt_o;
  logic [1:0] chains_o, valid_o, last_chains;
  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_col, n_col1, n_post, n_done, n_clr, log_bad, cur_lat = 1, lat_cnt = 0;

  assign meas_fin = auto_meas ? fin_auto : fin_man;

  cal_seq #(.SAMPLES(SAMPLES), .CHAINS(3), .LOG_W(4), .LOG_COUNT(LOGC), .TYPE_EN(2'b11)) u0 (
    .clk(clk), .rst(rst), .init_i(init_i), .meas_fin_i(meas_fin),
    .rx_chain_mask_i(mask), .go_o(go_o), .cal_sel_o(cal_sel_o),
    .log_cnt_o(log_cnt_o), .collect_o(collect_o), .acc_clr_o(acc_clr_o),
    .post_o(post_o), .chains_o(chains_o), .done_o(done_o), .valid_o(valid_o));

  always #4 clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (collect_o) begin
      n_col++;
      if (cal_sel_o == 1'b1) n_col1++;
    end
    if (post_o) begin
      n_post++;
      last_chains = chains_o;
    end
    if (done_o) n_done++;
    if (acc_clr_o) n_clr++;
    if (go_o && cal_sel_o == 1'b0) begin
      if (log_cnt_o != LOGC) log_bad++;
    end else if (log_cnt_o != 4'd0) log_bad++;
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      report();
    end
  end

  // Measurement unit model
  always @(negedge clk) begin
    if (!auto_meas || !go_o) begin
      fin_auto = 1'b0; lat_cnt = 0;
    end else if (fin_auto) begin
      fin_auto = 1'b0;
    end else if (lat_cnt >= cur_lat) begin
      fin_auto = 1'b1; lat_cnt = 0;
    end else lat_cnt++;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clear();
    n_col = 0; n_col1 = 0; n_post = 0; n_done = 0; n_clr = 0; log_bad = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && n_done == 0; i++) step();
  endtask

  initial begin
    clear();
    // R1: reset state
    repeat (3) step();
    chk("R1 go", go_o, 0); chk("R1 collect", collect_o, 0);
    chk("R1 post", post_o, 0); chk("R1 done", done_o, 0);
    chk("R1 clr", acc_clr_o, 0); chk("R1 valid", valid_o, 0);
    rst = 1'b0; step();
    chk("R1 idle go", go_o, 0); chk("R1 idle valid", valid_o, 0);

    // Table-driven full passes
    for (int v = 0; v < 8; v++) begin
      mask = VEC[v][7:5];
      cur_lat = int'(VEC[v][2:0]);
      auto_meas = 1'b1;
      clear();
      init_i = 1'b1; step(); init_i = 1'b0;
      wait_done(); step(); step();
      chk("R5 posts", n_post, 2);
      chk("R5 chains", last_chains, int'(VEC[v][4:3]));
      chk("R6 valid", valid_o, 3);
      chk("R8 done count", n_done, 1);
      chk("R7 handoff clears", n_clr, 2);
      chk("R10 total collects", n_col, 2 * SAMPLES);
      chk("R10 temp collects", n_col1, SAMPLES);
      chk("R11 log field", log_bad, 0);
    end

    // Directed: start response with manual measurement unit
    auto_meas = 1'b0; fin_man = 1'b0;
    clear();
    init_i = 1'b1; step(); init_i = 1'b0;
    chk("R2 valid cleared", valid_o, 0);
    chk("R2 clr pulse", acc_clr_o, 1);
    chk("R2 go", go_o, 1);
    chk("R2 first type", cal_sel_o, 0);
    chk("R11 iq log", log_cnt_o, int'(LOGC));
    repeat (5) step();
    chk("R3 go held", go_o, 1);
    chk("R3 no collect", n_col, 0);
    fin_man = 1'b1; step(); fin_man = 1'b0;
    chk("R3 go dropped", go_o, 0);
    chk("R3 collect waits", collect_o, 0);
    step();
    chk("R4 collect", collect_o, 1);
    chk("R4 relaunch", go_o, 1);
    chk("R4 no post", post_o, 0);
    // R9: start request while running
    init_i = 1'b1; repeat (3) step(); init_i = 1'b0;
    chk("R9 no clr", n_clr, 1);
    chk("R9 valid kept", valid_o, 0);
    auto_meas = 1'b1;
    wait_done(); step(); step();
    chk("R9 collects", n_col, 2 * SAMPLES);
    chk("R9 valid end", valid_o, 3);
    chk("R9 done once", n_done, 1);
    report();
  end
endmodule